// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Sequencer

This block lets a host fetch words from a serial NOR flash as plain memory loads. A host read request carries a byte offset into a memory window. The sequencer turns it into one complete flash read transaction: it lowers chip select, clocks out a read opcode and an address, waits through an optional dummy stretch, and then collects one host word from the flash. After that it releases chip select and answers the host with the assembled word.

The whole framing of the flash transaction comes from one packed setup word. That word holds the opcode, the number of address bytes, the dummy length and whether the data phase uses one line or four. A separate switch register decides whether the window is live. While the switch is clear, the flash pins are left to a register-driven engine elsewhere, and any host read is refused with an error response.

The serial clock runs at half the system clock and idles low. Outgoing bits change while it is low and are taken by the flash on its rising edge. Incoming bits are sampled at the system edge that ends each high half.

Top module: `sflash_xip_reader`

## Requirements
- R1: A register write with `cfg_sel`=0 loads the setup word. Every accepted read starts with the opcode from setup bits 7:0, sent MSB first on `fl_io_out[0]` with `fl_io_oe`=4'b0001, over 8 serial clock cycles.
- R2: Setup bits 9:8 hold a value N, and the address phase then sends N+1 bytes on `fl_io_out[0]`, MSB first, with `fl_io_oe`=4'b0001. The bytes are the low (N+1)*8 bits of `req_addr`, zero-extended to 32 bits.
- R3: The dummy phase lasts (setup bits 11:10)*8 + (setup bits 31:24) serial clock cycles with `fl_io_oe`=0. A total of zero skips the phase. Setup bits 23:14 have no effect on the transaction.
- R4: When setup bits 13:12 are not 3, the data phase lasts WORD_BYTES*8 cycles and samples `fl_io_in[1]` once per cycle. Each byte arrives MSB first. The first byte received lands in `rsp_data[7:0]`, and each later byte goes in the next byte lane up.
- R5: When setup bits 13:12 equal 3, the data phase lasts WORD_BYTES*2 cycles and samples `fl_io_in[3:0]` as one nibble per cycle, high nibble of each byte first. The byte lanes are placed as in R4. Opcode and address stay single-line.
- R6: `fl_sclk` is low whenever `fl_cs_n` is high. Each serial cycle is one system cycle low followed by one system cycle high. `fl_io_out` changes only while `fl_sclk` is low.
- R7: `fl_cs_n` falls on the edge that accepts a request and stays low through the last data cycle. `rsp_ready` then pulses for exactly one cycle, with `rsp_err`=0, one system cycle after `fl_cs_n` has returned high.
- R8: A register write with `cfg_sel`=1 loads the switch bit from `cfg_wdata[0]`. A request made while the switch is 0 gets `rsp_ready`=1 and `rsp_err`=1 on the next cycle, and `fl_cs_n` never falls.
- R9: After reset, `fl_cs_n`=1, `fl_sclk`=0, `fl_io_oe`=0 and `rsp_ready`=0. The switch bit is also 0 after reset.
- R10: A request is taken only while the sequencer is idle and `rsp_ready` is low. `req_addr` is captured on that edge, so later changes to it do not alter the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 setup word, 1 switch |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Host read request, held until `rsp_ready` |
| req_addr | input | ADDR_W | Byte offset within the window |
| rsp_ready | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response carries an error (window disabled) |
| rsp_data | output | WORD_BYTES*8 | Assembled read word |
| fl_sclk | output | 1 | Serial flash clock |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_io_out | output | 4 | Flash data lines, outgoing values |
| fl_io_oe | output | 4 | Flash data line drive enables |
| fl_io_in | input | 4 | Flash data lines, incoming values |

## Verification
The bench builds the block with a 24-bit host offset, a four-byte host word and the quad data path enabled. With a 24-bit offset, a four-byte address setting is reached, and it must show a zero top byte on the wire. With the quad option on, the nibble path can be compared against the single-line path over the same word width. Setup words mix one-, three- and four-byte addresses with dummy lengths of 0, 5, 8 and 19 cycles. This exercises every phase transition, including the direct jump from address to data.

// File: rtl/sfxr_pkg.sv
`timescale 1ns/1ps
package sfxr_pkg;

   // Width of the outgoing shift register: opcode byte or a full 32-bit address
   localparam int unsigned TX_W = 32;

   typedef enum logic [1:0] {
      PH_CMD,
      PH_ADDR,
      PH_DUMMY,
      PH_DATA
   } phase_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SHIFT,
      ST_FIN
   } state_e;

   // Decoded transaction framing held by the setup register
   typedef struct packed {
      logic [7:0] opcode;
      logic [1:0] addr_field;   // address bytes minus one
      logic [1:0] dummy_bytes;  // dummy bytes of 8 cycles
      logic       quad;         // data phase on four lines
      logic [7:0] extra_dummy;  // additional dummy cycles
   } setup_t;

endpackage

// File: rtl/sfxr_cfg_regs.sv
`timescale 1ns/1ps
module sfxr_cfg_regs
   import sfxr_pkg::*;
#(
   parameter bit QUAD_EN = 1'b1
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic        cfg_sel,
   input  logic [31:0] cfg_wdata,
   output setup_t      setup,
   output logic        map_en
);

   setup_t setup_q;
   logic   map_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         setup_q <= '0;
         map_q   <= 1'b0;
      end else if (cfg_we) begin
         if (cfg_sel) begin
            map_q <= cfg_wdata[0];
         end else begin
            setup_q.opcode      <= cfg_wdata[7:0];
            setup_q.addr_field  <= cfg_wdata[9:8];
            setup_q.dummy_bytes <= cfg_wdata[11:10];
            setup_q.quad        <= (cfg_wdata[13:12] == 2'b11);
            setup_q.extra_dummy <= cfg_wdata[31:24];
         end
      end
   end

   // Bits 23:14 carry nothing for the read path
   logic unused_wdata;
   assign unused_wdata = ^cfg_wdata[23:14];

   generate
      if (QUAD_EN) begin : g_quad
         assign setup = setup_q;
      end else begin : g_single_only
         logic unused_quad;
         assign unused_quad = setup_q.quad;
         always_comb begin
            setup      = setup_q;
            setup.quad = 1'b0;
         end
      end
   endgenerate

   assign map_en = map_q;

endmodule

// File: rtl/sfxr_shifter.sv
`timescale 1ns/1ps
module sfxr_shifter
   import sfxr_pkg::*;
#(
   parameter int unsigned WORD_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_load,
   input  logic [TX_W-1:0]   tx_val,
   input  logic              tx_step,
   input  logic              rx_sample,
   input  logic              quad,
   input  logic [3:0]        io_in,
   output logic              tx_bit,
   output logic [WORD_W-1:0] rx_stream
);

   logic [TX_W-1:0]   tx_q;
   logic [WORD_W-1:0] rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
      end else if (tx_load) begin
         tx_q <= tx_val;
      end else if (tx_step) begin
         tx_q <= {tx_q[TX_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q <= '0;
      end else if (rx_sample) begin
         if (quad) rx_q <= {rx_q[WORD_W-5:0], io_in};
         else      rx_q <= {rx_q[WORD_W-2:0], io_in[1]};
      end
   end

   assign tx_bit    = tx_q[TX_W-1];
   assign rx_stream = rx_q;

endmodule

// File: rtl/sfxr_byte_order.sv
`timescale 1ns/1ps
module sfxr_byte_order #(
   parameter int unsigned BYTES = 4
)(
   input  logic [BYTES*8-1:0] stream,
   output logic [BYTES*8-1:0] word
);

   // First received byte sits at the top of the stream; it goes to lane 0
   generate
      for (genvar b = 0; b < BYTES; b++) begin : g_lane
         assign word[b*8 +: 8] = stream[(BYTES-1-b)*8 +: 8];
      end
   endgenerate

endmodule

// File: rtl/sflash_xip_reader.sv
`timescale 1ns/1ps
module sflash_xip_reader
   import sfxr_pkg::*;
#(
   parameter int unsigned ADDR_W     = 24,
   parameter int unsigned WORD_BYTES = 4,
   parameter bit          QUAD_EN    = 1'b1
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic                    cfg_sel,
   input  logic [31:0]             cfg_wdata,
   input  logic                    req_valid,
   input  logic [ADDR_W-1:0]       req_addr,
   output logic                    rsp_ready,
   output logic                    rsp_err,
   output logic [WORD_BYTES*8-1:0] rsp_data,
   output logic                    fl_sclk,
   output logic                    fl_cs_n,
   output logic [3:0]              fl_io_out,
   output logic [3:0]              fl_io_oe,
   input  logic [3:0]              fl_io_in
);

   localparam int unsigned WORD_W    = WORD_BYTES * 8;
   localparam int unsigned DUMMY_MAX = 3 * 8 + 255;
   localparam int unsigned MAX_CYC   = (WORD_W > DUMMY_MAX) ? WORD_W : DUMMY_MAX;
   localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

   generate
      if (ADDR_W < 1 || ADDR_W > TX_W) begin : g_bad_addr_w
         $error("ADDR_W must lie between 1 and 32");
      end
      if (WORD_BYTES < 1) begin : g_bad_word
         $error("WORD_BYTES must be at least 1");
      end
   endgenerate

   setup_t setup;
   logic   map_en;

   sfxr_cfg_regs #(.QUAD_EN(QUAD_EN)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .setup     (setup),
      .map_en    (map_en)
   );

   state_e            state_q;
   phase_e            ph_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              sclk_q;
   logic              cs_n_q;
   logic              ready_q;
   logic              err_q;
   logic [WORD_W-1:0] data_q;
   logic [TX_W-1:0]   addr_q;

   // Phase lengths in serial clock cycles
   logic [CNT_W-1:0]  addr_cyc;
   logic [CNT_W-1:0]  dummy_cyc;
   logic [CNT_W-1:0]  data_cyc;
   logic [2:0]        addr_bytes;
   logic [4:0]        addr_lshift;

   assign addr_bytes  = {1'b0, setup.addr_field} + 3'd1;
   assign addr_cyc    = CNT_W'({addr_bytes, 3'b000});
   assign dummy_cyc   = CNT_W'({setup.dummy_bytes, 3'b000}) + CNT_W'(setup.extra_dummy);
   assign data_cyc    = setup.quad ? CNT_W'(WORD_BYTES * 2) : CNT_W'(WORD_W);
   assign addr_lshift = {2'd3 - setup.addr_field, 3'b000};

   logic accept;
   logic refuse;
   logic fall;
   logic last;

   assign accept = (state_q == ST_IDLE) && req_valid && !ready_q && map_en;
   assign refuse = (state_q == ST_IDLE) && req_valid && !ready_q && !map_en;
   assign fall   = (state_q == ST_SHIFT) && sclk_q;
   assign last   = (cnt_q == CNT_W'(1));

   // Shifter control
   logic            tx_load;
   logic [TX_W-1:0] tx_val;
   logic            tx_bit;
   logic            rx_sample;
   logic [WORD_W-1:0] rx_stream;
   logic [WORD_W-1:0] rx_word;

   assign tx_load   = accept || (fall && last && ph_q == PH_CMD);
   assign tx_val    = accept ? {setup.opcode, {(TX_W-8){1'b0}}} : (addr_q << addr_lshift);
   assign rx_sample = fall && (ph_q == PH_DATA);

   sfxr_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_load   (tx_load),
      .tx_val    (tx_val),
      .tx_step   (fall),
      .rx_sample (rx_sample),
      .quad      (setup.quad),
      .io_in     (fl_io_in),
      .tx_bit    (tx_bit),
      .rx_stream (rx_stream)
   );

   sfxr_byte_order #(.BYTES(WORD_BYTES)) u_order (
      .stream (rx_stream),
      .word   (rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ph_q    <= PH_CMD;
         cnt_q   <= '0;
         sclk_q  <= 1'b0;
         cs_n_q  <= 1'b1;
         ready_q <= 1'b0;
         err_q   <= 1'b0;
         data_q  <= '0;
         addr_q  <= '0;
      end else begin
         ready_q <= 1'b0;
         err_q   <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q <= ST_SHIFT;
                  ph_q    <= PH_CMD;
                  cnt_q   <= CNT_W'(8);
                  cs_n_q  <= 1'b0;
                  addr_q  <= TX_W'(req_addr);
               end else if (refuse) begin
                  ready_q <= 1'b1;
                  err_q   <= 1'b1;
               end
            end
            ST_SHIFT: begin
               sclk_q <= ~sclk_q;
               if (sclk_q) begin
                  if (last) begin
                     unique case (ph_q)
                        PH_CMD: begin
                           ph_q  <= PH_ADDR;
                           cnt_q <= addr_cyc;
                        end
                        PH_ADDR: begin
                           if (dummy_cyc != '0) begin
                              ph_q  <= PH_DUMMY;
                              cnt_q <= dummy_cyc;
                           end else begin
                              ph_q  <= PH_DATA;
                              cnt_q <= data_cyc;
                           end
                        end
                        PH_DUMMY: begin
                           ph_q  <= PH_DATA;
                           cnt_q <= data_cyc;
                        end
                        PH_DATA: begin
                           state_q <= ST_FIN;
                           cs_n_q  <= 1'b1;
                        end
                        default: ph_q <= PH_CMD;
                     endcase
                  end else begin
                     cnt_q <= cnt_q - CNT_W'(1);
                  end
               end
            end
            ST_FIN: begin
               state_q <= ST_IDLE;
               ready_q <= 1'b1;
               data_q  <= rx_word;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   logic drive_line;
   assign drive_line = (state_q == ST_SHIFT) && (ph_q == PH_CMD || ph_q == PH_ADDR);

   assign fl_sclk   = sclk_q;
   assign fl_cs_n   = cs_n_q;
   assign fl_io_out = {3'b000, tx_bit & drive_line};
   assign fl_io_oe  = {3'b000, drive_line};
   assign rsp_ready = ready_q;
   assign rsp_err   = err_q;
   assign rsp_data  = data_q;

endmodule

// File: rtl/sfxr_checker.sv
`timescale 1ns/1ps
module sfxr_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       fl_sclk,
   input logic       fl_cs_n,
   input logic [3:0] fl_io_out,
   input logic [3:0] fl_io_oe,
   input logic       rsp_ready,
   input logic       rsp_err
);

   // R6: serial clock rests low outside a transaction
   p_sclk_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fl_cs_n |-> !fl_sclk);

   // R6: outgoing lines hold steady through the high half
   p_out_stable_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_sclk && !fl_cs_n) |-> $stable(fl_io_out));

   // R1: lines are driven only inside a selected transaction
   p_drive_selected_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_io_oe != 4'b0000) |-> !fl_cs_n);

   // R7: a good response follows chip-select release
   p_ready_after_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_ready && !rsp_err) |-> (fl_cs_n && $past(fl_cs_n)));

   // R7: response strobe lasts one cycle
   p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ready |=> !rsp_ready);

   // R8: a refused request never selects the flash
   p_err_unselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_ready && rsp_err) |-> (fl_cs_n && $past(fl_cs_n)));

   // R8: the error flag only accompanies a response
   p_err_with_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_ready);

endmodule

bind sflash_xip_reader sfxr_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fl_sclk   (fl_sclk),
   .fl_cs_n   (fl_cs_n),
   .fl_io_out (fl_io_out),
   .fl_io_oe  (fl_io_oe),
   .rsp_ready (rsp_ready),
   .rsp_err   (rsp_err)
);

// File: tb/sflash_xip_reader_tb.sv
`timescale 1ns/1ps
module sflash_xip_reader_tb;

   localparam int unsigned AW = 24;
   localparam int unsigned WB = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we, cfg_sel;
   logic [31:0] cfg_wdata;
   logic        req_valid;
   logic [AW-1:0] req_addr;
   logic        rsp_ready, rsp_err;
   logic [WB*8-1:0] rsp_data;
   logic        fl_sclk, fl_cs_n;
   logic [3:0]  fl_io_out, fl_io_oe, fl_io_in;

   always #2.5 clk = ~clk;

   sflash_xip_reader #(.ADDR_W(AW), .WORD_BYTES(WB), .QUAD_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_addr(req_addr),
      .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_data(rsp_data),
      .fl_sclk(fl_sclk), .fl_cs_n(fl_cs_n),
      .fl_io_out(fl_io_out), .fl_io_oe(fl_io_oe), .fl_io_in(fl_io_in)
   );

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Bench view of the programmed framing
   int          cur_nab   = 1;
   int          cur_dummy = 0;
   bit          cur_quad  = 1'b0;
   logic [7:0]  cur_op    = 8'h00;
   bit          sw_on     = 1'b0;

   function automatic logic [7:0] fbyte(input logic [31:0] a);
      return (a[7:0] * 8'd29) ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'hA5;
   endfunction

   function automatic logic [31:0] mask_addr(input logic [AW-1:0] a, input int nab);
      logic [31:0] x;
      x = 32'(a);
      if (nab < 4) x = x & ((32'h1 << (8 * nab)) - 32'h1);
      return x;
   endfunction

   function automatic logic [31:0] exp_word(input logic [31:0] ma);
      logic [31:0] w;
      for (int k = 0; k < WB; k++) w[k*8 +: 8] = fbyte(ma + 32'(k));
      return w;
   endfunction

   // Flash model
   int          fl_cnt = 0;
   logic [7:0]  fl_op;
   logic [31:0] fl_addr;
   bit          in_txn = 1'b0;
   int          cs_falls = 0;
   logic [31:0] exp_addr_q;
   int          idle_bad = 0;

   always @(negedge fl_cs_n) begin
      fl_cnt  = 0;
      fl_op   = 8'h00;
      fl_addr = 32'h0;
      in_txn  = 1'b1;
      cs_falls++;
   end

   always @(posedge fl_sclk) begin
      int n, hdr, d;
      logic [7:0] b;
      n   = fl_cnt;
      hdr = 8 + cur_nab * 8 + cur_dummy;
      if (n < 8) fl_op = {fl_op[6:0], fl_io_out[0]};
      else if (n < 8 + cur_nab * 8) fl_addr = {fl_addr[30:0], fl_io_out[0]};
      if (n >= hdr) begin
         d = n - hdr;
         if (cur_quad) begin
            b = fbyte(fl_addr + 32'(d / 2));
            fl_io_in <= (d % 2 == 0) ? b[7:4] : b[3:0];
         end else begin
            b = fbyte(fl_addr + 32'(d / 8));
            fl_io_in <= {2'b00, b[7 - (d % 8)], 1'b0};
         end
      end
      fl_cnt = n + 1;
   end

   always @(posedge fl_cs_n) begin
      if (in_txn) begin
         int tot;
         in_txn = 1'b0;
         tot = 8 + cur_nab * 8 + cur_dummy + (cur_quad ? WB * 2 : WB * 8);
         chk(fl_op == cur_op, "R1 opcode on wire", 64'(fl_op), 64'(cur_op));
         chk(fl_addr == exp_addr_q, "R2/R10 address on wire", 64'(fl_addr), 64'(exp_addr_q));
         chk(fl_cnt == tot, "R3/R4/R5 serial cycles per transaction", 64'(fl_cnt), 64'(tot));
      end
   end

   always @(negedge clk) begin
      if (rst_n && fl_cs_n === 1'b1 && (fl_sclk !== 1'b0 || fl_io_oe !== 4'b0000)) idle_bad++;
   end

   // Scoreboard
   typedef struct {
      logic        err;
      logic [31:0] data;
      string       tag;
   } exp_t;

   exp_t sb_q[$];

   always @(negedge clk) begin
      if (rst_n && rsp_ready === 1'b1) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R7 unexpected response", 64'(rsp_data), 64'h0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk(rsp_err == e.err, {e.tag, " error flag"}, 64'(rsp_err), 64'(e.err));
            if (!e.err) begin
               chk(rsp_data == e.data, {e.tag, " data word"}, 64'(rsp_data), 64'(e.data));
               chk(fl_cs_n == 1'b1, "R7 chip select released at response", 64'(fl_cs_n), 64'h1);
            end
         end
      end
   end

   task automatic reg_write(input logic sel, input logic [31:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_setup(input logic [31:0] v);
      reg_write(1'b0, v);
      cur_op    = v[7:0];
      cur_nab   = int'(v[9:8]) + 1;
      cur_dummy = int'(v[11:10]) * 8 + int'(v[31:24]);
      cur_quad  = (v[13:12] == 2'b11);
   endtask

   task automatic set_switch(input bit on);
      reg_write(1'b1, {31'h0, on});
      sw_on = on;
   endtask

   task automatic host_read(input logic [AW-1:0] a);
      exp_t e;
      e.err  = !sw_on;
      exp_addr_q = mask_addr(a, cur_nab);
      e.data = exp_word(exp_addr_q);
      e.tag  = !sw_on ? "R8 refused read" : (cur_quad ? "R5 quad read" : "R4 single read");
      sb_q.push_back(e);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_addr = ~a;   // R10: late change must not reach the wire
      while (rsp_ready !== 1'b1) @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      chk(rsp_ready == 1'b0, "R7 ready is a single pulse", 64'(rsp_ready), 64'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog R7 no completion actual=%0d expected=%0d", sb_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int falls0;
      cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = 32'h0;
      req_valid = 1'b0; req_addr = '0; fl_io_in = 4'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(fl_cs_n == 1'b1, "R9 reset chip select", 64'(fl_cs_n), 64'h1);
      chk(fl_sclk == 1'b0, "R9 reset serial clock", 64'(fl_sclk), 64'h0);
      chk(fl_io_oe == 4'h0, "R9 reset drive enables", 64'(fl_io_oe), 64'h0);
      chk(rsp_ready == 1'b0, "R9 reset response strobe", 64'(rsp_ready), 64'h0);

      // R9/R8: switch comes out of reset clear
      host_read(24'h000010);
      chk(cs_falls == 0, "R8 no select while switch clear", 64'(cs_falls), 64'h0);

      set_switch(1'b1);

      // Normal read, three address bytes, no dummy
      set_setup(32'h0002_0203);
      host_read(24'h000100);
      host_read(24'h0ABCDE);
      host_read(24'hFFFFFC);

      // Fast read, one dummy byte
      set_setup(32'h0002_060B);
      host_read(24'h001234);

      // Quad data, one dummy byte
      set_setup(32'h0002_366B);
      host_read(24'h00F0F0);
      host_read(24'h123457);

      // Four address bytes, five extra dummy cycles, single line
      set_setup(32'h0502_0313);
      host_read(24'hC0FFEE);

      // One address byte, two dummy bytes plus three, quad data
      set_setup(32'h0300_38EB);
      host_read(24'h4567AB);

      // Window switched off again
      set_switch(1'b0);
      falls0 = cs_falls;
      host_read(24'h000200);
      chk(cs_falls == falls0, "R8 no select after switch cleared", 64'(cs_falls), 64'(falls0));

      repeat (4) @(negedge clk);
      chk(sb_q.size() == 0, "R7 every request answered", 64'(sb_q.size()), 64'h0);
      chk(idle_bad == 0, "R6 clock low and lines released while idle", 64'(idle_bad), 64'h0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule